// File: doc/BRIEF.md
# Hot-Plug Slot Command and Event Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port, together with the event and interrupt logic that sits behind them. Configuration software writes both registers through one 32-bit write port with four byte enables. Bytes 0 and 1 hold slot control and bytes 2 and 3 hold slot status. The same 32-bit word can be read back at any time.

The physical side of the slot reports four one-cycle pulses: card insertion, card removal, presence at power-up, and an attention-button press. The block turns slot status and its enables into one pending condition. When message interrupts are on, it sends a one-cycle message request with a 5-bit vector each time that condition changes value. When they are off, it drives a level interrupt that follows the condition.

All pins are plain control and status pins. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. A write is accepted in the cycle its enable is high.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, read-back is 0x0000_03C0. In slot control, every enable and the interlock-control bit are 0, and both indicator fields (bits 7:6 and 9:8) hold the off code 2'b11. Slot status is all zero, and the interrupt line, the message request and the busy flag are low.
- R2: A write with byte enable 0 or 1 set is one command. The writable control bits (0, 3, 4, 5, 7:6, 9:8) take the new data in the enabled bytes. Command-completed (status bit 4) is then set by the same clock edge.
- R3: Control bit 11 (interlock control) always reads 0. Each write that carries a 1 in bit 11 with byte enable 1 set inverts status bit 7 (interlock engaged).
- R4: The condition is pending when control bit 5 (hot-plug interrupt enable) is 1 and, for at least one of the event bits 0, 3 and 4, both the status bit and the control enable at the same position are 1. With message interrupts off, the level interrupt equals the pending condition one clock after the registers change.
- R5: With message interrupts on, every change of the pending condition gives one message request pulse, one cycle wide, one clock after the registers change. The pulse carries the vector input sampled at that edge, and the level interrupt stays low.
- R6: Raising an event whose status bit is already 1, or issuing a command while command-completed is already 1, gives no new message request.
- R7: Status bits 0 (button pressed), 3 (presence changed) and 4 (command completed) are write-1-to-clear through byte 2. Writing 0 to them leaves them unchanged.
- R8: Insertion sets status bit 6 (presence) and bit 3. Removal clears bit 6 and sets bit 3. Power-up presence sets bit 6 only. A button press sets bit 0.
- R9: An insertion or removal that arrives while status bit 7 is 1 is refused. The busy output is high for the following cycle, and bits 6 and 3 keep their values.
- R10: When a register write and a hardware event fall in the same cycle, both take effect on the same edge, and a set from the event wins over a write-1-to-clear of the same bit.
- R11: A write with only byte 2 or 3 enabled is not a command and leaves slot control and command-completed unchanged. Control bytes whose enables are low keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_be | input | 4 | Byte enables; bytes 0-1 control, bytes 2-3 status |
| cfg_wr_data | input | 32 | Write data; control in [15:0], status in [31:16] |
| cfg_rd_data | output | 32 | Read-back {slot status, slot control} |
| card_insert | input | 1 | Card insertion pulse |
| card_remove | input | 1 | Card removal pulse |
| card_coldplug | input | 1 | Presence at power-up pulse, no event |
| attn_press | input | 1 | Attention button pulse |
| plug_busy | output | 1 | High for one cycle after a refused insertion or removal |
| msi_on | input | 1 | Message interrupts enabled |
| msg_num_cfg | input | VEC_W | Interrupt message number to send |
| intx_level | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message request |
| msi_msg_num | output | VEC_W | Vector attached to the last request |

## Verification
A software write and a hardware event can land on the same clock edge. Examples are a control write paired with a button press, and a write-1-to-clear of the button bit paired with a new press. The bench drives both in one cycle. It judges the result from the read-back word on the next cycle and from the interrupt line one cycle later. The expected state has both updates applied, and the hardware set wins over the clear. Refused insertions are also paired with interlock toggles, to confirm that a refusal uses the interlock state from before that edge.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W  = 16;
  localparam int WORD_W = 2 * REG_W;
  localparam int BE_W   = WORD_W / 8;

  // status bit positions
  localparam int S_BTN  = 0;
  localparam int S_PCHG = 3;
  localparam int S_CMD  = 4;
  localparam int S_PRES = 6;
  localparam int S_LOCK = 7;

  // control bit positions
  localparam int C_BTNE = 0;
  localparam int C_PCHE = 3;
  localparam int C_CMDE = 4;
  localparam int C_HPIE = 5;
  localparam int C_LOCK = 11;

  localparam logic [REG_W-1:0] CTL_RESET = 16'h03C0;
  localparam logic [REG_W-1:0] CTL_WMASK = 16'h03F9;
  localparam logic [REG_W-1:0] EVT_MASK  = 16'h0019;
endpackage

// File: rtl/hp_lane_merge.sv
module hp_lane_merge #(
  parameter int LANES = 2
) (
  input  logic [8*LANES-1:0] old_val,
  input  logic [8*LANES-1:0] new_val,
  input  logic [LANES-1:0]   lane_en,
  output logic [8*LANES-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = lane_en[g] ? new_val[8*g +: 8] : old_val[8*g +: 8];
  end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ev_insert,
  input  logic              ev_remove,
  input  logic              ev_cold,
  input  logic              ev_btn,
  output logic [REG_W-1:0]  ctl_q,
  output logic [REG_W-1:0]  sts_q,
  output logic              busy_q
);
  localparam int HALF = BE_W / 2;

  logic [REG_W-1:0] ctl_m, ctl_d, clr_raw, clr_mask, sts_d;
  logic [HALF-1:0]  ctl_lanes, sts_lanes;
  logic             ctl_wr, lock_hit, plug_try, refuse;

  assign ctl_lanes = wr_be[HALF-1:0] & {HALF{wr_en}};
  assign sts_lanes = wr_be[BE_W-1:HALF] & {HALF{wr_en}};
  assign ctl_wr    = |ctl_lanes;

  hp_lane_merge #(.LANES(HALF)) u_ctl_merge (
    .old_val(ctl_q), .new_val(wr_data[REG_W-1:0]),
    .lane_en(ctl_lanes), .merged(ctl_m));

  hp_lane_merge #(.LANES(HALF)) u_clr_merge (
    .old_val('0), .new_val(wr_data[WORD_W-1:REG_W]),
    .lane_en(sts_lanes), .merged(clr_raw));

  assign clr_mask = clr_raw & EVT_MASK;
  assign lock_hit = ctl_m[C_LOCK];
  assign ctl_d    = ctl_m & CTL_WMASK;
  assign plug_try = ev_insert | ev_remove;
  assign refuse   = plug_try & sts_q[S_LOCK];

  always_comb begin
    sts_d = sts_q & ~clr_mask;
    if (lock_hit) sts_d[S_LOCK] = ~sts_q[S_LOCK];
    if (ev_btn)   sts_d[S_BTN]  = 1'b1;
    if (ev_cold)  sts_d[S_PRES] = 1'b1;
    if (!sts_q[S_LOCK]) begin
      if (ev_insert) begin
        sts_d[S_PRES] = 1'b1;
        sts_d[S_PCHG] = 1'b1;
      end else if (ev_remove) begin
        sts_d[S_PRES] = 1'b0;
        sts_d[S_PCHG] = 1'b1;
      end
    end
    if (ctl_wr) sts_d[S_CMD] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RESET;
      sts_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      sts_q  <= sts_d;
      busy_q <= refuse;
    end
  end

  // R2: a control write completes as a command on the same edge
  p_cmd_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> sts_q[S_CMD]);

  // R3: each 1 written to interlock control flips interlock status
  p_lock_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[C_LOCK]) |=> (sts_q[S_LOCK] != $past(sts_q[S_LOCK])));

  // R9: a refused plug attempt leaves presence untouched and raises busy
  p_refuse_keeps_pres_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !ev_cold) |=> $stable(sts_q[S_PRES]));

  p_refuse_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> busy_q);
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctl,
  input  logic [REG_W-1:0] sts,
  input  logic             msi_on,
  input  logic [VEC_W-1:0] vec_cfg,
  output logic             intx_q,
  output logic             msi_q,
  output logic [VEC_W-1:0] vec_q
);
  logic pend, pend_q, flip;

  assign pend = ctl[C_HPIE] & (|(sts & ctl & EVT_MASK));
  assign flip = pend ^ pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      intx_q <= 1'b0;
      msi_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend;
      intx_q <= ~msi_on & pend;
      msi_q  <= msi_on & flip;
      if (msi_on && flip) vec_q <= vec_cfg;
    end
  end

  // R4: the level interrupt never rises without the hot-plug enable
  p_intx_needs_hpie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    intx_q |-> $past(ctl[C_HPIE]));

  // R5: message requests only while message interrupts were enabled
  p_msi_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_q |-> $past(msi_on));

  // R5: a message request and the level line are never active together
  p_msi_excl_intx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_q |-> !intx_q);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [BE_W-1:0]   cfg_wr_be,
  input  logic [WORD_W-1:0] cfg_wr_data,
  output logic [WORD_W-1:0] cfg_rd_data,
  input  logic              card_insert,
  input  logic              card_remove,
  input  logic              card_coldplug,
  input  logic              attn_press,
  output logic              plug_busy,
  input  logic              msi_on,
  input  logic [VEC_W-1:0]  msg_num_cfg,
  output logic              intx_level,
  output logic              msi_req,
  output logic [VEC_W-1:0]  msi_msg_num
);
  logic [REG_W-1:0] ctl_q, sts_q;

  hp_slot_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_be(cfg_wr_be), .wr_data(cfg_wr_data),
    .ev_insert(card_insert), .ev_remove(card_remove),
    .ev_cold(card_coldplug), .ev_btn(attn_press),
    .ctl_q(ctl_q), .sts_q(sts_q), .busy_q(plug_busy));

  hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
    .clk(clk), .rst_n(rst_n),
    .ctl(ctl_q), .sts(sts_q),
    .msi_on(msi_on), .vec_cfg(msg_num_cfg),
    .intx_q(intx_level), .msi_q(msi_req), .vec_q(msi_msg_num));

  assign cfg_rd_data = {sts_q, ctl_q};

  // R3: interlock control is never visible in read-back
  p_lock_ctl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[C_LOCK] == 1'b0);
endmodule

// File: tb/hp_slot_ctrl_bench.sv
module hp_slot_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_be = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        card_insert = 1'b0, card_remove = 1'b0, card_coldplug = 1'b0, attn_press = 1'b0;
  logic        plug_busy;
  logic        msi_on = 1'b0;
  logic [4:0]  msg_num_cfg = '0;
  logic        intx_level, msi_req;
  logic [4:0]  msi_msg_num;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hp_slot_ctrl u_hp_slot_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data),
    .card_insert(card_insert), .card_remove(card_remove),
    .card_coldplug(card_coldplug), .attn_press(attn_press),
    .plug_busy(plug_busy), .msi_on(msi_on), .msg_num_cfg(msg_num_cfg),
    .intx_level(intx_level), .msi_req(msi_req), .msi_msg_num(msi_msg_num));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    msi_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive a write (optionally with events) for one cycle; returns at the next negedge
  task automatic cyc(input logic we, input logic [3:0] be, input logic [31:0] d,
                     input logic ins, input logic rem, input logic cold, input logic btn);
    cfg_wr_en = we; cfg_wr_be = be; cfg_wr_data = d;
    card_insert = ins; card_remove = rem; card_coldplug = cold; attn_press = btn;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_be = '0; cfg_wr_data = '0;
    card_insert = 1'b0; card_remove = 1'b0; card_coldplug = 1'b0; attn_press = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 readback", cfg_rd_data, 32'h0000_03C0);
    check("R1 intx", {31'd0, intx_level}, 32'd0);
    check("R1 msi", {31'd0, msi_req}, 32'd0);
    check("R1 busy", {31'd0, plug_busy}, 32'd0);
  endtask

  task automatic t_command();
    do_reset();
    cyc(1, 4'b0001, 32'h0000_0000, 0, 0, 0, 0);
    check("R2 byte0 command", cfg_rd_data, 32'h0010_0300);
    cyc(1, 4'b0100, 32'h0010_0000, 0, 0, 0, 0);
    check("R7 clear cmd done", cfg_rd_data, 32'h0000_0300);
  endtask

  task automatic t_bytes();
    do_reset();
    cyc(1, 4'b0010, 32'h0000_F4FF, 0, 0, 0, 0);
    check("R11 only byte1 written", cfg_rd_data, 32'h0010_00C0);
    cyc(1, 4'b0100, 32'h0010_0000, 0, 0, 0, 0);
    cyc(1, 4'b1000, 32'hFFFF_FFFF, 0, 0, 0, 0);
    check("R11 status-only write no command", cfg_rd_data, 32'h0000_00C0);
  endtask

  task automatic t_w1c();
    do_reset();
    cyc(0, 4'b0000, 32'h0, 0, 0, 0, 1);
    check("R8 button sets bit0", cfg_rd_data, 32'h0001_03C0);
    cyc(1, 4'b0100, 32'h0000_0000, 0, 0, 0, 0);
    check("R7 zero write keeps", cfg_rd_data, 32'h0001_03C0);
    cyc(1, 4'b0100, 32'h0001_0000, 0, 0, 0, 0);
    check("R7 one clears", cfg_rd_data, 32'h0000_03C0);
  endtask

  task automatic t_interlock();
    do_reset();
    cyc(1, 4'b0010, 32'h0000_0800, 0, 0, 0, 0);
    check("R3 toggle on", cfg_rd_data, 32'h0090_00C0);
    cyc(1, 4'b0010, 32'h0000_0800, 0, 0, 0, 0);
    check("R3 toggle off", cfg_rd_data, 32'h0010_00C0);
  endtask

  task automatic t_plug();
    do_reset();
    cyc(0, 4'b0000, 32'h0, 0, 0, 1, 0);
    check("R8 coldplug", cfg_rd_data, 32'h0040_03C0);
    cyc(0, 4'b0000, 32'h0, 0, 1, 0, 0);
    check("R8 removal", cfg_rd_data, 32'h0008_03C0);
    cyc(1, 4'b0100, 32'h0008_0000, 0, 0, 0, 0);
    check("R7 clear presence change", cfg_rd_data, 32'h0000_03C0);
    cyc(0, 4'b0000, 32'h0, 1, 0, 0, 0);
    check("R8 insertion", cfg_rd_data, 32'h0048_03C0);
  endtask

  task automatic t_busy();
    do_reset();
    cyc(1, 4'b0010, 32'h0000_0800, 0, 0, 0, 0);
    cyc(0, 4'b0000, 32'h0, 1, 0, 0, 0);
    check("R9 busy on insert", {31'd0, plug_busy}, 32'd1);
    check("R9 insert refused", cfg_rd_data, 32'h0090_00C0);
    cyc(0, 4'b0000, 32'h0, 0, 1, 0, 0);
    check("R9 busy on remove", {31'd0, plug_busy}, 32'd1);
    check("R9 remove refused", cfg_rd_data, 32'h0090_00C0);
    // unlock and insert in the same cycle: refusal uses the old lock
    cyc(1, 4'b0010, 32'h0000_0800, 1, 0, 0, 0);
    check("R9 refused with same-cycle unlock", cfg_rd_data, 32'h0010_00C0);
    cyc(0, 4'b0000, 32'h0, 1, 0, 0, 0);
    check("R9 accepted after unlock busy", {31'd0, plug_busy}, 32'd0);
    check("R9 accepted after unlock", cfg_rd_data, 32'h0058_00C0);
  endtask

  task automatic t_intx();
    do_reset();
    cyc(1, 4'b0011, 32'h0000_03E8, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 no pending from unmasked cmd", {31'd0, intx_level}, 32'd0);
    cyc(0, 4'b0000, 32'h0, 1, 0, 0, 0);
    check("R4 intx not yet", {31'd0, intx_level}, 32'd0);
    @(negedge clk);
    check("R4 intx rises", {31'd0, intx_level}, 32'd1);
    cyc(1, 4'b0011, 32'h0000_03C8, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 hpie off drops intx", {31'd0, intx_level}, 32'd0);
    cyc(1, 4'b0011, 32'h0000_03E8, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 hpie on restores intx", {31'd0, intx_level}, 32'd1);
    cyc(1, 4'b0100, 32'h0008_0000, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 clear drops intx", {31'd0, intx_level}, 32'd0);
    check("R4 no msi when off", {31'd0, msi_req}, 32'd0);
  endtask

  task automatic t_msi();
    do_reset();
    msi_on = 1'b1;
    msg_num_cfg = 5'd19;
    cyc(1, 4'b0011, 32'h0000_03F0, 0, 0, 0, 0);
    check("R5 no pulse before latency", {31'd0, msi_req}, 32'd0);
    @(negedge clk);
    check("R5 pulse on rise", {31'd0, msi_req}, 32'd1);
    check("R5 vector", {27'd0, msi_msg_num}, 32'd19);
    check("R5 intx low with msi", {31'd0, intx_level}, 32'd0);
    @(negedge clk);
    check("R5 single cycle", {31'd0, msi_req}, 32'd0);
    cyc(1, 4'b0011, 32'h0000_03F0, 0, 0, 0, 0);
    check("R6 repeat cmd no pulse a", {31'd0, msi_req}, 32'd0);
    @(negedge clk);
    check("R6 repeat cmd no pulse b", {31'd0, msi_req}, 32'd0);
    msg_num_cfg = 5'd31;
    cyc(1, 4'b0100, 32'h0010_0000, 0, 0, 0, 0);
    @(negedge clk);
    check("R5 pulse on fall", {31'd0, msi_req}, 32'd1);
    check("R5 vector 31", {27'd0, msi_msg_num}, 32'd31);
  endtask

  task automatic t_collide();
    do_reset();
    cyc(1, 4'b0011, 32'h0000_03E1, 0, 0, 0, 1);
    check("R10 write and button together", cfg_rd_data, 32'h0011_03E1);
    @(negedge clk);
    check("R10 intx after collision", {31'd0, intx_level}, 32'd1);
    cyc(1, 4'b0100, 32'h0001_0000, 0, 0, 0, 1);
    check("R10 event wins over clear", cfg_rd_data, 32'h0011_03E1);
    @(negedge clk);
    check("R10 intx held", {31'd0, intx_level}, 32'd1);
    cyc(1, 4'b0100, 32'h0001_0000, 1, 0, 0, 0);
    check("R10 clear with insertion", cfg_rd_data, 32'h0058_03E1);
  endtask

  initial begin
    t_reset();
    t_command();
    t_bytes();
    t_w1c();
    t_interlock();
    t_plug();
    t_busy();
    t_intx();
    t_msi();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule